// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block holds the software-visible bus-master registers of a two-channel disk controller. It decodes a 16-byte I/O window. Channel 0 owns the first 8-byte slice and channel 1 owns the second. Each slice has four single-byte registers at the bottom: transfer control, a mode byte shared by both channels, transfer status and per-channel transfer timing. Above them sits a 32-bit pointer to the channel's descriptor table.

Requests arrive on a simple register bus. The bus carries a 4-bit byte address, separate read and write strobes, a 2-bit size code and 32-bit right-justified data. Read data is combinational and valid while the read strobe is high. Writes take effect at the clock edge on which the write strobe is sampled.

The block also talks to an interrupt aggregator. It receives the two per-channel pending bits and shows them inside the shared mode byte. It returns the two software-written mask bits and a one-cycle request to recompute the interrupt line. The DMA engine receives each channel's start and direction bits. It drives the active flag and the error and interrupt set pulses back into status.

Top module: `bm_dma_regwin`

## Requirements
- R1: After reset, the control, mode mask, status, timing and pointer registers of both channels read 0, and maskOut, startOut and dirOut are 0.
- R2: Control byte (slice offset 0) stores bit 0 (start, driven on startOut) and bit 3 (direction, driven on dirOut); all other bits read 0.
- R3: Slice offset 1 of either channel is the same shared mode byte. It reads bits 5:4 as the mask bits, bits 3:2 as pendIn[1:0] and 0 elsewhere. A write through either channel changes only bits 5:4.
- R4: After a mode write, maskOut shows the new mask bits in the next cycle, and recalcReq is high for exactly that one cycle.
- R5: Status byte (offset 2) reads bit 0 as that channel's dmaActive input. A write stores data bits 6:5, clears bit 1 (error) and bit 2 (interrupt) where the data has 1s and leaves them elsewhere, and leaves bits 7, 4 and 3 at 0.
- R6: errPulse sets status bit 1 and irqPulse sets status bit 2; a set wins over a clear written in the same cycle.
- R7: Timing byte (offset 3) is a full 8-bit read/write register, separate for each channel.
- R8: At offsets 0 to 3, only size code 0 (one byte) is honoured. Size code 1 (two bytes) reads 0xFFFF and codes 2 and 3 read 0xFFFFFFFF. Writes of those sizes change nothing.
- R9: The descriptor pointer (offsets 4 to 7) accepts byte access at any offset, 16-bit access at offsets 4 and 6, and 32-bit access at offset 4. Its bits 1:0 always read 0. Any other access reads all ones for its size, and its write is ignored.
- R10: Channel 1 registers sit at byte addresses 8 to 15 and are independent of channel 0 except for the shared mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte address in the window |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busSize | input | 2 | 0 = byte, 1 = 16-bit, 2/3 = 32-bit |
| busWdata | input | 32 | Right-justified write data |
| busRdata | output | 32 | Right-justified read data, 0 when idle |
| pendIn | input | 2 | Per-channel pending bits from the aggregator |
| dmaActive | input | 2 | Per-channel engine-active flag |
| errPulse | input | 2 | Per-channel error set pulse |
| irqPulse | input | 2 | Per-channel interrupt set pulse |
| maskOut | output | 2 | Written mask bits to the aggregator |
| recalcReq | output | 1 | One-cycle recompute request |
| startOut | output | 2 | Per-channel start bit |
| dirOut | output | 2 | Per-channel direction bit |

## Verification
The hardest case to reach is a status write that clears the interrupt bit in the very cycle the engine pulses it. The bench sets up a single cycle in which the write strobe and irqPulse are both high for channel 1. It then reads back that the bit survived.

Writes of the wrong size to the byte registers are a second hard case, because they are silent. The bench first loads known values into those registers. It then issues the wrong-size write and reads the registers back, so that any leak shows up. Misaligned pointer accesses are handled the same way, around a pointer that was loaded beforehand.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
  localparam int BUS_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES = BUS_W / BYTE_W;

  typedef enum logic [2:0] {
    RD_NONE, RD_CMD, RD_MODE, RD_STAT, RD_TIM, RD_PTR, RD_ONES
  } rdKind_e;

  typedef struct packed {
    logic             chan;
    logic             cmdWr;
    logic             modeWr;
    logic             statWr;
    logic             timWr;
    logic [LANES-1:0] ptrBe;
    logic [1:0]       ptrShift;
    rdKind_e          rdKind;
    logic [BUS_W-1:0] sizeMask;
  } strobe_t;
endpackage

// File: rtl/bm_dma_ctrl.sv
module bm_dma_ctrl
  import bm_dma_pkg::*;
#(
  parameter int SLICE_W = 3,
  localparam int ADDR_W = SLICE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  output strobe_t           strb
);
  logic [SLICE_W-1:0] off;
  logic               lowHalf;
  logic [1:0]         ptrOff;
  logic               ptrOk;
  logic               lowOk;

  assign off     = busAddr[SLICE_W-1:0];
  assign lowHalf = !off[SLICE_W-1];
  assign ptrOff  = off[1:0];
  assign lowOk   = (busSize == 2'd0);

  always_comb begin
    unique case (busSize)
      2'd0:    ptrOk = 1'b1;
      2'd1:    ptrOk = !ptrOff[0];
      default: ptrOk = (ptrOff == 2'd0);
    endcase
  end

  always_comb begin
    strb = '0;
    strb.chan = busAddr[ADDR_W-1];
    strb.ptrShift = ptrOff;
    strb.rdKind = RD_NONE;
    unique case (busSize)
      2'd0:    strb.sizeMask = 32'h0000_00FF;
      2'd1:    strb.sizeMask = 32'h0000_FFFF;
      default: strb.sizeMask = 32'hFFFF_FFFF;
    endcase
    if (lowHalf) begin
      if (busWr && lowOk) begin
        strb.cmdWr  = (ptrOff == 2'd0);
        strb.modeWr = (ptrOff == 2'd1);
        strb.statWr = (ptrOff == 2'd2);
        strb.timWr  = (ptrOff == 2'd3);
      end
      if (busRd) begin
        if (!lowOk) strb.rdKind = RD_ONES;
        else begin
          unique case (ptrOff)
            2'd0:    strb.rdKind = RD_CMD;
            2'd1:    strb.rdKind = RD_MODE;
            2'd2:    strb.rdKind = RD_STAT;
            default: strb.rdKind = RD_TIM;
          endcase
        end
      end
    end else begin
      if (busWr && ptrOk) begin
        unique case (busSize)
          2'd0:    strb.ptrBe = 4'b0001 << ptrOff;
          2'd1:    strb.ptrBe = 4'b0011 << ptrOff;
          default: strb.ptrBe = 4'b1111;
        endcase
      end
      if (busRd) strb.rdKind = ptrOk ? RD_PTR : RD_ONES;
    end
  end

  // At most one byte-register write strobe per cycle (R8 decode)
  assert_one_low_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cmdWr, strb.modeWr, strb.statWr, strb.timWr, |strb.ptrBe}));
  // Wrong-size access to bytes 0..3 never writes (R8)
  assert_size_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busSize != 2'd0 && !busAddr[SLICE_W-1]) |-> !(strb.cmdWr || strb.modeWr || strb.statWr || strb.timWr));
endmodule

// File: rtl/bm_dma_datapath.sv
module bm_dma_datapath
  import bm_dma_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [NUM_CH-1:0] pendIn,
  input  logic [NUM_CH-1:0] dmaActive,
  input  logic [NUM_CH-1:0] errPulse,
  input  logic [NUM_CH-1:0] irqPulse,
  output logic [NUM_CH-1:0] maskOut,
  output logic              recalcReq,
  output logic [NUM_CH-1:0] startOut,
  output logic [NUM_CH-1:0] dirOut
);
  logic [BYTE_W-1:0] wByte;
  logic [BUS_W-1:0]  wShifted;
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] cmdStart, cmdDir, statErr, statIrq;
  logic [1:0]        statKeep [NUM_CH];
  logic [BYTE_W-1:0] timReg   [NUM_CH];
  logic [BUS_W-1:0]  ptrReg   [NUM_CH];

  assign wByte    = busWdata[BYTE_W-1:0];
  assign wShifted = busWdata << (BYTE_W * strb.ptrShift);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      recalcReq <= 1'b0;
    end else begin
      recalcReq <= strb.modeWr;
      if (strb.modeWr) maskReg <= wByte[5:4];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (strb.chan == c[0]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdStart[c] <= 1'b0;
        cmdDir[c]   <= 1'b0;
        statErr[c]  <= 1'b0;
        statIrq[c]  <= 1'b0;
        statKeep[c] <= '0;
        timReg[c]   <= '0;
        ptrReg[c]   <= '0;
      end else begin
        if (strb.cmdWr && sel) begin
          cmdStart[c] <= wByte[0];
          cmdDir[c]   <= wByte[3];
        end
        if (strb.statWr && sel) statKeep[c] <= wByte[6:5];
        if (errPulse[c]) statErr[c] <= 1'b1;
        else if (strb.statWr && sel && wByte[1]) statErr[c] <= 1'b0;
        if (irqPulse[c]) statIrq[c] <= 1'b1;
        else if (strb.statWr && sel && wByte[2]) statIrq[c] <= 1'b0;
        if (strb.timWr && sel) timReg[c] <= wByte;
        for (int l = 0; l < LANES; l++) begin
          if (strb.ptrBe[l] && sel) ptrReg[c][l*BYTE_W +: BYTE_W] <= wShifted[l*BYTE_W +: BYTE_W];
        end
        if (sel && strb.ptrBe[0]) ptrReg[c][1:0] <= 2'b00;
      end
    end

    // Set beats a same-cycle clear (R6)
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[c] |=> statIrq[c]);
    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rstN)
      errPulse[c] |=> statErr[c]);
    // Pointer only moves on a pointer write to this channel (R9)
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      !(sel && |strb.ptrBe) |=> $stable(ptrReg[c]));
    // Control bits only move on a control write (R2)
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(sel && strb.cmdWr) |=> ($stable(cmdStart[c]) && $stable(cmdDir[c])));
  end

  assign maskOut  = maskReg;
  assign startOut = cmdStart;
  assign dirOut   = cmdDir;

  always_comb begin
    logic [BUS_W-1:0] ptrSel;
    ptrSel = ptrReg[strb.chan];
    busRdata = '0;
    unique case (strb.rdKind)
      RD_CMD:  busRdata[7:0] = {4'b0, cmdDir[strb.chan], 2'b0, cmdStart[strb.chan]};
      RD_MODE: busRdata[7:0] = {2'b0, maskReg, pendIn, 2'b0};
      RD_STAT: busRdata[7:0] = {1'b0, statKeep[strb.chan], 2'b0, statIrq[strb.chan],
                                statErr[strb.chan], dmaActive[strb.chan]};
      RD_TIM:  busRdata[7:0] = timReg[strb.chan];
      RD_PTR:  busRdata = (ptrSel >> (BYTE_W * strb.ptrShift)) & strb.sizeMask;
      RD_ONES: busRdata = strb.sizeMask;
      default: busRdata = '0;
    endcase
  end

  // Recompute request follows a mode write by exactly one cycle (R4)
  assert_recalc_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> recalcReq);
  assert_recalc_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modeWr |=> !recalcReq);
  // Mask bits only change on a mode write (R3)
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modeWr |=> $stable(maskReg));
endmodule

// File: rtl/bm_dma_regwin.sv
module bm_dma_regwin
  import bm_dma_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int SLICE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SLICE_W:0]   busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [1:0]         busSize,
  input  logic [BUS_W-1:0]   busWdata,
  output logic [BUS_W-1:0]   busRdata,
  input  logic [NUM_CH-1:0]  pendIn,
  input  logic [NUM_CH-1:0]  dmaActive,
  input  logic [NUM_CH-1:0]  errPulse,
  input  logic [NUM_CH-1:0]  irqPulse,
  output logic [NUM_CH-1:0]  maskOut,
  output logic               recalcReq,
  output logic [NUM_CH-1:0]  startOut,
  output logic [NUM_CH-1:0]  dirOut
);
  strobe_t strb;

  bm_dma_ctrl #(.SLICE_W(SLICE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busSize(busSize), .strb(strb)
  );

  bm_dma_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .pendIn(pendIn), .dmaActive(dmaActive),
    .errPulse(errPulse), .irqPulse(irqPulse), .maskOut(maskOut),
    .recalcReq(recalcReq), .startOut(startOut), .dirOut(dirOut)
  );
endmodule

// File: tb/bm_dma_regwin_tb.sv
module bm_dma_regwin_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  pendIn = '0, dmaActive = '0, errPulse = '0, irqPulse = '0;
  logic [1:0]  maskOut, startOut, dirOut;
  logic        recalcReq;
  int nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  bm_dma_regwin u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .pendIn(pendIn),
    .dmaActive(dmaActive), .errPulse(errPulse), .irqPulse(irqPulse),
    .maskOut(maskOut), .recalcReq(recalcReq), .startOut(startOut), .dirOut(dirOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = s; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = s; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [3:0] a, input logic [1:0] s,
                           input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, s, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a++) begin
      if (a[2:0] < 4) readCheck("R1", a[3:0], 2'd0, 32'h0);
    end
    readCheck("R1", 4'd4, 2'd2, 32'h0);
    readCheck("R1", 4'd12, 2'd2, 32'h0);
    check("R1", {26'b0, maskOut, startOut, dirOut}, 32'h0);
  endtask

  task automatic t_cmd();
    busWrite(4'd0, 2'd0, 32'hFF);
    readCheck("R2", 4'd0, 2'd0, 32'h09);
    check("R2", {30'b0, startOut}, 32'h1);
    check("R2", {30'b0, dirOut}, 32'h1);
    readCheck("R10", 4'd8, 2'd0, 32'h0);
  endtask

  task automatic t_mode();
    pendIn = 2'b11;
    @(negedge clk);
    busAddr = 4'd1; busSize = 2'd0; busWdata = 32'hFF; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
    check("R4", {31'b0, recalcReq}, 32'h1);
    check("R4", {30'b0, maskOut}, 32'h3);
    @(posedge clk); #1;
    check("R4", {31'b0, recalcReq}, 32'h0);
    readCheck("R3", 4'd1, 2'd0, 32'h3C);
    readCheck("R3", 4'd9, 2'd0, 32'h3C);
    busWrite(4'd9, 2'd0, 32'h10);
    readCheck("R3", 4'd1, 2'd0, 32'h1C);
    check("R3", {30'b0, maskOut}, 32'h1);
    pendIn = 2'b00;
    readCheck("R3", 4'd9, 2'd0, 32'h10);
  endtask

  task automatic t_status();
    dmaActive = 2'b01;
    @(negedge clk);
    errPulse = 2'b01; irqPulse = 2'b01;
    @(negedge clk);
    errPulse = 2'b00; irqPulse = 2'b00;
    readCheck("R6", 4'd2, 2'd0, 32'h07);
    busWrite(4'd2, 2'd0, 32'h62);
    readCheck("R5", 4'd2, 2'd0, 32'h65);
    busWrite(4'd2, 2'd0, 32'h00);
    readCheck("R5", 4'd2, 2'd0, 32'h05);
    busWrite(4'd2, 2'd0, 32'h9C);
    readCheck("R5", 4'd2, 2'd0, 32'h01);
    dmaActive = 2'b00;
    readCheck("R5", 4'd2, 2'd0, 32'h00);
  endtask

  task automatic t_setwins();
    @(negedge clk);
    busAddr = 4'd10; busSize = 2'd0; busWdata = 32'h06; busWr = 1'b1; irqPulse = 2'b10;
    @(posedge clk); #1;
    busWr = 1'b0; irqPulse = 2'b00;
    readCheck("R6", 4'd10, 2'd0, 32'h04);
    readCheck("R10", 4'd2, 2'd0, 32'h00);
  endtask

  task automatic t_timing();
    busWrite(4'd3, 2'd0, 32'hA5);
    busWrite(4'd11, 2'd0, 32'h5A);
    readCheck("R7", 4'd3, 2'd0, 32'hA5);
    readCheck("R7", 4'd11, 2'd0, 32'h5A);
  endtask

  task automatic t_size();
    busWrite(4'd0, 2'd1, 32'h0000_0000);
    readCheck("R8", 4'd0, 2'd0, 32'h09);
    busWrite(4'd3, 2'd2, 32'h0000_0000);
    readCheck("R8", 4'd3, 2'd0, 32'hA5);
    busWrite(4'd1, 2'd1, 32'h0000_0000);
    check("R8", {30'b0, maskOut}, 32'h1);
    readCheck("R8", 4'd0, 2'd1, 32'h0000_FFFF);
    readCheck("R8", 4'd2, 2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_ptr();
    busWrite(4'd4, 2'd2, 32'h1234_5677);
    readCheck("R9", 4'd4, 2'd2, 32'h1234_5674);
    busWrite(4'd6, 2'd0, 32'hAB);
    readCheck("R9", 4'd4, 2'd2, 32'h12AB_5674);
    readCheck("R9", 4'd6, 2'd1, 32'h0000_12AB);
    busWrite(4'd5, 2'd1, 32'hFFFF);
    readCheck("R9", 4'd4, 2'd2, 32'h12AB_5674);
    readCheck("R9", 4'd5, 2'd1, 32'h0000_FFFF);
    busWrite(4'd4, 2'd0, 32'hFF);
    readCheck("R9", 4'd4, 2'd0, 32'h0000_00FC);
    readCheck("R10", 4'd12, 2'd2, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_cmd();
    t_mode();
    t_status();
    t_setwins();
    t_timing();
    t_size();
    t_ptr();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule